// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block caches recent logical-to-physical page translations for one CPU address port. A request carries a logical address and the identifier of the address space that issued it. The block splits the address into a page number and a byte offset, and it compares the page number and identifier against every stored entry in the same cycle. On a match, it answers one cycle later with the stored frame number placed above the unchanged offset.

When no entry matches, the block stops accepting requests. It asks an external page-table walker for the frame and waits for the walker's reply. A valid reply is installed in the cache and returned as the response. A reply marked not-valid is returned as a protection fault and is not installed.

Each entry keeps the identifier it was filled under. Translations for the same page from different address spaces can therefore sit side by side in the cache. Software can drop every entry at once, or only the entries of one address space.

Top module: `tlb`

## Requirements
- R1: The logical address is split into a page number (bits 31..12) and an offset (bits 11..0). On a hit, rsp_valid_o rises in the cycle after the request is accepted, with rsp_paddr_o = {frame, offset} and rsp_fault_o = 0. req_ready_o stays high throughout a hit.
- R2: All entries are compared in the same cycle, and at most one entry ever matches a lookup. A page that was installed earliest in a full table still hits.
- R3: A hit requires both the page number and the identifier to match. The same page can be cached under two identifiers at once, and each lookup returns its own frame.
- R4: On a miss, in the next cycle:
  - walk_req_o is high;
  - walk_vpn_o and walk_asid_o carry the missing page and identifier;
  - req_ready_o is low;
  - no response is given until the refill is taken.
- R5: A refill is taken in a cycle where walk_req_o and walk_valid_i are both high. In the next cycle:
  - the response is given with the walker's frame and the original offset;
  - walk_req_o is low;
  - req_ready_o is high again.
  A valid refill is installed, so a later lookup of that page hits.
- R6: A refill with walk_pte_ok_i = 0 returns rsp_fault_o = 1 with rsp_paddr_o = 0 and installs nothing, so the same lookup misses again.
- R7: A refill is installed into the lowest-numbered invalid entry. When all entries are valid, a round-robin pointer picks the victim. The pointer starts at entry 0 after reset and advances by one on each refill installed into a full table.
- R8: A pulse on flush_all_i invalidates every entry, and later lookups miss. A refill taken in the same cycle as the pulse is still answered but is not kept.
- R9: A pulse on flush_asid_i invalidates only the entries whose identifier equals flush_asid_id_i. Entries of other identifiers still hit.
- R10: After reset, req_ready_o = 1, rsp_valid_o = 0, walk_req_o = 0, and every entry is invalid, so the first lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translate request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | 32 | Logical address |
| req_asid_i | input | 8 | Address-space identifier of the request |
| rsp_valid_o | output | 1 | Response valid, one cycle wide |
| rsp_paddr_o | output | 32 | Physical address, zero on a fault |
| rsp_fault_o | output | 1 | Protection fault |
| walk_req_o | output | 1 | Page-table lookup requested |
| walk_vpn_o | output | 20 | Page number to look up |
| walk_asid_o | output | 8 | Identifier to look up |
| walk_valid_i | input | 1 | Walker reply valid |
| walk_pfn_i | input | 20 | Frame number from the walker |
| walk_pte_ok_i | input | 1 | Reply entry valid bit |
| flush_all_i | input | 1 | Invalidate every entry |
| flush_asid_i | input | 1 | Invalidate the entries of one identifier |
| flush_asid_id_i | input | 8 | Identifier to invalidate |

## Verification
Round-robin eviction is the hardest behaviour to reach from the ports. It needs a table that is full of valid entries, and entries are only ever written by misses. The stimulus first flushes the table, then misses on sixteen distinct pages in a row, then forces further misses. After each eviction it probes which of the oldest pages still hit. A second hard case is a whole-table flush that lands in the same cycle as a refill. The bench handles it by pulsing the flush exactly when it presents the walker's reply.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  parameter int unsigned VA_W_DEF      = 32;
  parameter int unsigned PAGE_BITS_DEF = 12;
  parameter int unsigned ASID_W_DEF    = 8;
  parameter int unsigned PFN_W_DEF     = 20;
  parameter int unsigned ENTRIES_DEF   = 16;

  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_WALK   = 1'b1
  } tlb_state_e;
endpackage

// File: rtl/tlb_entry_array.sv
`timescale 1ns/1ps
module tlb_entry_array #(
  parameter int unsigned N      = 16,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PFN_W  = 20,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_id_i,
  output logic [N-1:0]      hit_vec_o,
  output logic [N-1:0]      valid_vec_o,
  output logic [PFN_W-1:0]  hit_pfn_o
);
  logic [N-1:0][PFN_W-1:0] pfn_masked;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic              valid_q, valid_d;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q, asid_d;
    logic              wr_sel;

    assign wr_sel = wr_en_i && (wr_idx_i == IDX_W'(i));
    assign asid_d = wr_sel ? wr_asid_i : asid_q;

    // flush beats a same-cycle install
    always_comb begin
      valid_d = valid_q | wr_sel;
      if (flush_all_i || (flush_asid_i && asid_d == flush_asid_id_i))
        valid_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        vpn_q   <= '0;
        asid_q  <= '0;
      end else begin
        valid_q <= valid_d;
        if (wr_sel) begin
          vpn_q  <= wr_vpn_i;
          asid_q <= wr_asid_i;
        end
      end
    end

    logic [PFN_W-1:0] pfn_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pfn_q <= '0;
      else if (wr_sel) pfn_q <= wr_pfn_i;
    end

    assign hit_vec_o[i]   = valid_q && (vpn_q == lk_vpn_i) && (asid_q == lk_asid_i);
    assign valid_vec_o[i] = valid_q;
    assign pfn_masked[i]  = hit_vec_o[i] ? pfn_q : '0;
  end

  always_comb begin
    hit_pfn_o = '0;
    for (int k = 0; k < N; k++) hit_pfn_o = hit_pfn_o | pfn_masked[k];
  end
endmodule

// File: rtl/tlb_victim_sel.sv
`timescale 1ns/1ps
module tlb_victim_sel #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_vec_i,
  input  logic             alloc_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             all_valid;

  assign all_valid = &valid_vec_i;

  // lowest invalid index
  always_comb begin
    free_idx = '0;
    for (int k = N - 1; k >= 0; k--)
      if (!valid_vec_i[k]) free_idx = IDX_W'(k);
  end

  assign victim_o = all_valid ? rr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (alloc_i && all_valid)
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/tlb.sv
`timescale 1ns/1ps
module tlb
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W      = VA_W_DEF,
  parameter int unsigned PAGE_BITS = PAGE_BITS_DEF,
  parameter int unsigned ASID_W    = ASID_W_DEF,
  parameter int unsigned PFN_W     = PFN_W_DEF,
  parameter int unsigned N_ENTRIES = ENTRIES_DEF,
  localparam int unsigned VPN_W    = VA_W - PAGE_BITS,
  localparam int unsigned PA_W     = PFN_W + PAGE_BITS,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [ASID_W-1:0] req_asid_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic              rsp_fault_o,
  output logic              walk_req_o,
  output logic [VPN_W-1:0]  walk_vpn_o,
  output logic [ASID_W-1:0] walk_asid_o,
  input  logic              walk_valid_i,
  input  logic [PFN_W-1:0]  walk_pfn_i,
  input  logic              walk_pte_ok_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_id_i
);
  tlb_state_e           state_q;
  logic [VPN_W-1:0]     pend_vpn_q;
  logic [ASID_W-1:0]    pend_asid_q;
  logic [PAGE_BITS-1:0] pend_off_q;
  logic                 rsp_valid_q, rsp_fault_q;
  logic [PA_W-1:0]      rsp_paddr_q;

  logic [N_ENTRIES-1:0] hit_vec, valid_vec;
  logic [PFN_W-1:0]     hit_pfn;
  logic [IDX_W-1:0]     victim_idx;
  logic                 accept, lookup_hit, refill_take, install;
  logic [VPN_W-1:0]     req_vpn;
  logic [PAGE_BITS-1:0] req_off;

  assign req_vpn     = req_vaddr_i[VA_W-1:PAGE_BITS];
  assign req_off     = req_vaddr_i[PAGE_BITS-1:0];
  assign req_ready_o = (state_q == ST_LOOKUP);
  assign accept      = req_valid_i && req_ready_o;
  assign lookup_hit  = |hit_vec;
  assign walk_req_o  = (state_q == ST_WALK);
  assign refill_take = walk_req_o && walk_valid_i;
  assign install     = refill_take && walk_pte_ok_i;

  tlb_entry_array #(
    .N(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) u_array (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .lk_vpn_i        (req_vpn),
    .lk_asid_i       (req_asid_i),
    .wr_en_i         (install),
    .wr_idx_i        (victim_idx),
    .wr_vpn_i        (pend_vpn_q),
    .wr_asid_i       (pend_asid_q),
    .wr_pfn_i        (walk_pfn_i),
    .flush_all_i     (flush_all_i),
    .flush_asid_i    (flush_asid_i),
    .flush_asid_id_i (flush_asid_id_i),
    .hit_vec_o       (hit_vec),
    .valid_vec_o     (valid_vec),
    .hit_pfn_o       (hit_pfn)
  );

  tlb_victim_sel #(.N(N_ENTRIES)) u_victim (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_vec_i (valid_vec),
    .alloc_i     (install),
    .victim_o    (victim_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_LOOKUP;
      pend_vpn_q  <= '0;
      pend_asid_q <= '0;
      pend_off_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        if (lookup_hit) begin
          rsp_valid_q <= 1'b1;
          rsp_fault_q <= 1'b0;
          rsp_paddr_q <= {hit_pfn, req_off};
        end else begin
          state_q     <= ST_WALK;
          pend_vpn_q  <= req_vpn;
          pend_asid_q <= req_asid_i;
          pend_off_q  <= req_off;
        end
      end
      if (refill_take) begin
        state_q     <= ST_LOOKUP;
        rsp_valid_q <= 1'b1;
        rsp_fault_q <= !walk_pte_ok_i;
        rsp_paddr_q <= walk_pte_ok_i ? {walk_pfn_i, pend_off_q} : '0;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_fault_o = rsp_fault_q;
  assign rsp_paddr_o = rsp_paddr_q;
  assign walk_vpn_o  = pend_vpn_q;
  assign walk_asid_o = pend_asid_q;
endmodule

// File: rtl/tlb_checker.sv
`timescale 1ns/1ps
module tlb_checker #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned PA_W      = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic                 rsp_valid_o,
  input logic                 rsp_fault_o,
  input logic [PA_W-1:0]      rsp_paddr_o,
  input logic                 walk_req_o,
  input logic                 walk_valid_i,
  input logic                 walk_pte_ok_i,
  input logic [VPN_W-1:0]     walk_vpn_o,
  input logic                 flush_all_i,
  input logic [N_ENTRIES-1:0] hit_vec,
  input logic [N_ENTRIES-1:0] valid_vec
);
  p_single_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  p_hit_next_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && |hit_vec) |=> (rsp_valid_o && !rsp_fault_o && req_ready_o));

  p_miss_walk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !(|hit_vec)) |=> (walk_req_o && !req_ready_o && !rsp_valid_o));

  p_walk_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && !walk_valid_i) |=> (walk_req_o && $stable(walk_vpn_o) && !rsp_valid_o));

  p_refill_rsp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && walk_valid_i) |=> (rsp_valid_o && !walk_req_o && req_ready_o));

  p_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && walk_valid_i && !walk_pte_ok_i) |=> (rsp_fault_o && rsp_paddr_o == '0));

  p_flush_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_vec == '0));
endmodule

bind tlb tlb_checker #(
  .N_ENTRIES (N_ENTRIES),
  .VPN_W     (VPN_W),
  .PA_W      (PA_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_fault_o   (rsp_fault_o),
  .rsp_paddr_o   (rsp_paddr_o),
  .walk_req_o    (walk_req_o),
  .walk_valid_i  (walk_valid_i),
  .walk_pte_ok_i (walk_pte_ok_i),
  .walk_vpn_o    (walk_vpn_o),
  .flush_all_i   (flush_all_i),
  .hit_vec       (hit_vec),
  .valid_vec     (valid_vec)
);

// File: tb/sim_tlb.sv
`timescale 1ns/1ps
module sim_tlb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_asid = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic [7:0]  walk_asid;
  logic        walk_valid = 1'b0;
  logic [19:0] walk_pfn = '0;
  logic        walk_ok = 1'b0;
  logic        flush_all = 1'b0;
  logic        flush_asid = 1'b0;
  logic [7:0]  flush_id = '0;

  tlb u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_asid_i(req_asid),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault),
    .walk_req_o(walk_req), .walk_vpn_o(walk_vpn), .walk_asid_o(walk_asid),
    .walk_valid_i(walk_valid), .walk_pfn_i(walk_pfn), .walk_pte_ok_i(walk_ok),
    .flush_all_i(flush_all), .flush_asid_i(flush_asid), .flush_asid_id_i(flush_id)
  );

  typedef struct {
    logic [31:0] pa;
    logic        flt;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check_eq(input string tag, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops and compares every response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check_eq("R1", "unexpected rsp_valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check_eq(e.tag, "rsp_paddr", rsp_paddr, e.pa);
        check_eq(e.tag, "rsp_fault", rsp_fault, e.flt);
      end
    end
  end

  task automatic xlat(input logic [31:0] va, input logic [7:0] asid, input bit miss,
                      input logic [19:0] pfn, input bit ok, input bit flush_with,
                      input string tag);
    exp_t e;
    e.pa  = ok ? {pfn, va[11:0]} : 32'h0;
    e.flt = !ok;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_asid = asid;
    @(negedge clk);
    req_valid = 1'b0;
    check_eq(tag, "walk_req after request", walk_req, miss);
    if (miss) begin
      check_eq(tag, "ready low during walk", req_ready, 0);
      check_eq(tag, "no rsp before refill", rsp_valid, 0);
      check_eq(tag, "walk_vpn", walk_vpn, va[31:12]);
      check_eq(tag, "walk_asid", walk_asid, asid);
      walk_valid = 1'b1; walk_pfn = pfn; walk_ok = ok; flush_all = flush_with;
      @(negedge clk);
      walk_valid = 1'b0; flush_all = 1'b0;
      check_eq(tag, "walk_req cleared", walk_req, 0);
      check_eq(tag, "ready after refill", req_ready, 1);
    end else begin
      check_eq(tag, "ready high on hit", req_ready, 1);
    end
    @(negedge clk);
  endtask

  task automatic pulse_flush_all();
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
  endtask

  task automatic pulse_flush_asid(input logic [7:0] id);
    @(negedge clk); flush_asid = 1'b1; flush_id = id;
    @(negedge clk); flush_asid = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R10", "ready after reset", req_ready, 1);
    check_eq("R10", "rsp_valid after reset", rsp_valid, 0);
    check_eq("R10", "walk_req after reset", walk_req, 0);

    // first lookup misses (R10), then refill (R4, R5)
    xlat(32'h0001_2345, 8'd1, 1, 20'hABCDE, 1, 0, "R10");
    xlat(32'h0001_2FFF, 8'd1, 0, 20'hABCDE, 1, 0, "R1");
    xlat(32'h0001_2000, 8'd1, 0, 20'hABCDE, 1, 0, "R5");
    // same page, other identifier
    xlat(32'h0001_2AAA, 8'd2, 1, 20'h11111, 1, 0, "R3");
    xlat(32'h0001_2AAA, 8'd1, 0, 20'hABCDE, 1, 0, "R3");
    xlat(32'h0001_2001, 8'd2, 0, 20'h11111, 1, 0, "R3");
    // invalid page-table entry
    xlat(32'h0077_7123, 8'd1, 1, 20'h33333, 0, 0, "R6");
    xlat(32'h0077_7123, 8'd1, 1, 20'h22222, 1, 0, "R6");
    xlat(32'h0077_7FF0, 8'd1, 0, 20'h22222, 1, 0, "R4");
    // flush by identifier
    pulse_flush_asid(8'd1);
    xlat(32'h0001_2004, 8'd2, 0, 20'h11111, 1, 0, "R9");
    xlat(32'h0001_2004, 8'd1, 1, 20'h44444, 1, 0, "R9");
    xlat(32'h0077_7000, 8'd1, 1, 20'h22222, 1, 0, "R9");
    // flush everything
    pulse_flush_all();
    xlat(32'h0001_2004, 8'd2, 1, 20'h55555, 1, 0, "R8");
    // flush in the same cycle as a refill
    xlat(32'h0090_0010, 8'd4, 1, 20'h66666, 1, 1, "R8");
    xlat(32'h0090_0010, 8'd4, 1, 20'h66666, 1, 0, "R8");
    xlat(32'h0001_2004, 8'd2, 1, 20'h55555, 1, 0, "R8");
    // fill the table, then evict round-robin
    pulse_flush_all();
    for (int i = 0; i < 16; i++)
      xlat({20'h00100 + 20'(i), 12'h0}, 8'd3, 1, 20'h50000 + 20'(i), 1, 0, "R7");
    xlat({20'h00200, 12'h0}, 8'd3, 1, 20'h5AAAA, 1, 0, "R7");
    xlat({20'h0010F, 12'h0}, 8'd3, 0, 20'h5000F, 1, 0, "R2");
    xlat({20'h00101, 12'h0}, 8'd3, 0, 20'h50001, 1, 0, "R2");
    xlat({20'h00100, 12'h0}, 8'd3, 1, 20'h60000, 1, 0, "R7");
    xlat({20'h00101, 12'h0}, 8'd3, 1, 20'h60001, 1, 0, "R7");
    xlat({20'h00103, 12'h0}, 8'd3, 0, 20'h50003, 1, 0, "R7");
    xlat({20'h00102, 12'h0}, 8'd3, 1, 20'h60002, 1, 0, "R7");
    xlat({20'h00200, 12'h8}, 8'd3, 0, 20'h5AAAA, 1, 0, "R7");

    repeat (4) @(negedge clk);
    check_eq("R5", "responses outstanding", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule